// File: doc/BRIEF.md
# Single-Line Ownership Controller for Four Caching Masters

This block is the central point that keeps one cache line coherent across several caching masters that share a single memory. It records what kind of copy each master holds, and it serves one request at a time. For each request it sends snoops to the masters whose copies must change and waits for their acknowledgements. It writes a dirty copy back to memory when the rule for that request calls for it. Finally it fetches the line from memory when the requester needs data.

Three request kinds give a master exclusive ownership:

- **Read-for-exclusive** is for a master with no copy that plans a partial store. It gets the newest data and becomes the only holder.
- **Clean-for-exclusive** is for a master that already holds a copy. It keeps its own copy while all others are removed.
- **Make-exclusive** is for a full-line store. It removes every other copy and drops any dirty data they held.

A fourth kind, a shared read, lets masters build up clean shared copies. It downgrades any unique holder to shared and writes that holder's data back first if it is dirty.

A master raises its request and keeps it raised until it sees its one-cycle response. It must drop the request in that same response cycle. Requests that arrive together are served lowest index first. Requests that arrive while a transaction is under way wait until the block is idle.

Top module: `line_owner_ctrl`

## Requirements

**Encodings used by the requirements**

- Request kinds on `req_op`: 0 = shared read, 1 = read-for-exclusive, 2 = clean-for-exclusive, 3 = make-exclusive.
- Copy states on `line_state`: 0 = Invalid, 1 = Shared-Clean, 2 = Unique-Clean, 3 = Unique-Dirty.
- Master i's request kind is `req_op[2i+1:2i]`, and its copy state is `line_state[2i+1:2i]`.

**Requirements**

- R1: After reset every copy state is Invalid, and `busy`, `rsp_valid`, `snp_valid`, `mem_wr_en` and `mem_rd_en` are all low.
- R2: While any master's state is Unique-Clean or Unique-Dirty, every other master's state is Invalid.
- R3: When several masters request together, the lowest-indexed one is served first. `busy` is high from the cycle after acceptance through the response cycle, and the waiting master is served after that.
- R4: A read-for-exclusive sends an invalidating snoop (`snp_share` = 0) to every other master with a valid copy. It leaves the requester Unique-Clean and returns line data from memory (`rsp_has_data` = 1).
- R5: When a read-for-exclusive finds another master Unique-Dirty, that master's snoop data is written to memory. The memory read completes only after that write, so the returned data equals the written data.
- R6: When no other copy is dirty, a read-for-exclusive performs no memory write.
- R7: A clean-for-exclusive from a master holding a copy invalidates all other copies and leaves the requester Unique-Clean. It returns no data and makes no memory read or write.
- R8: A clean-for-exclusive from a master whose state is Invalid is served exactly as a read-for-exclusive.
- R9: A make-exclusive invalidates all other copies and discards any dirty data without a memory write. It leaves the requester Unique-Dirty, returns no data and makes no memory read.
- R10: A shared read snoops only Unique holders, with `snp_share` = 1. A Unique-Dirty holder is written back first. Snooped holders become Shared-Clean. Shared-Clean holders are not snooped. The requester becomes Shared-Clean with memory data.
- R11: A snoop on `snp_valid[i]` stays high until the cycle in which `snp_ack[i]` is sampled high. A memory write request stays high until `mem_wr_ack`.
- R12: Each response is a single-cycle pulse on exactly one bit of `rsp_valid`, and no snoop or memory access is active in that cycle.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NM | Per-master request, held until its response |
| req_op | input | 2*NM | Per-master request kind |
| busy | output | 1 | A transaction is in progress |
| rsp_valid | output | NM | One-cycle completion to the served master |
| rsp_has_data | output | 1 | The response carries line data |
| rsp_data | output | DW | Line data returned to the requester |
| snp_valid | output | NM | Snoop command per master |
| snp_share | output | 1 | Snoop kind: 1 = downgrade to shared, 0 = invalidate |
| snp_ack | input | NM | Snoop acknowledge per master |
| snp_data | input | NM*DW | Line data from each snooped master |
| mem_wr_en | output | 1 | Memory writeback request |
| mem_wr_data | output | DW | Writeback data |
| mem_wr_ack | input | 1 | Writeback accepted |
| mem_rd_en | output | 1 | Memory line read request |
| mem_rd_data | input | DW | Read data |
| mem_rd_valid | input | 1 | Read data valid |
| line_state | output | 2*NM | Current copy state of each master |

## Verification

**Snoop timing.** A request accepted at one clock edge raises `busy` and its snoops after that edge. A snoop acknowledged at an edge clears its bit and updates that master's state at the same edge. The controller moves to writeback, read or response one edge after the last acknowledge.

**Memory and response timing.** With memory answering one cycle after a request, a writeback or a read adds two cycles. The response pulse lasts one cycle, and the requester's new state appears at the edge that ends the pulse.

**How the checks keep to this timing.** The bench never counts a fixed number of cycles. It polls at falling edges for the response pulse, and it reads states, counters and the cleared response one falling edge later. Snoop, write and read counts and the cycle of each memory access are recorded at rising edges, so ordering is judged by cycle number.

// File: rtl/line_owner_ctrl.sv
module line_owner_ctrl #(
  parameter int NM = 4,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NM-1:0]     req_valid,
  input  logic [2*NM-1:0]   req_op,
  output logic              busy,
  output logic [NM-1:0]     rsp_valid,
  output logic              rsp_has_data,
  output logic [DW-1:0]     rsp_data,
  output logic [NM-1:0]     snp_valid,
  output logic              snp_share,
  input  logic [NM-1:0]     snp_ack,
  input  logic [NM*DW-1:0]  snp_data,
  output logic              mem_wr_en,
  output logic [DW-1:0]     mem_wr_data,
  input  logic              mem_wr_ack,
  output logic              mem_rd_en,
  input  logic [DW-1:0]     mem_rd_data,
  input  logic              mem_rd_valid,
  output logic [2*NM-1:0]   line_state
);
  localparam int IW = (NM > 1) ? $clog2(NM) : 1;
  localparam logic [1:0] OP_RS = 2'd0, OP_RE = 2'd1, OP_CE = 2'd2, OP_ME = 2'd3;
  localparam logic [1:0] L_I = 2'd0, L_SC = 2'd1, L_UC = 2'd2, L_UD = 2'd3;

  typedef enum logic [2:0] {IDLE, SNP, WB, RD, RSP} phase_t;

  phase_t          phase;
  logic [1:0]      st [NM];
  logic [IW-1:0]   cur_id, win;
  logic [1:0]      cur_op, win_op, eff_op;
  logic [NM-1:0]   pend, tgt;
  logic            share_q, wb_need;
  logic [DW-1:0]   wb_data, rd_data;
  logic            needs_data;

  always_comb begin
    win = '0;
    for (int i = NM - 1; i >= 0; i--)
      if (req_valid[i]) win = IW'(i);
  end

  assign win_op = req_op[2*win +: 2];
  assign eff_op = (win_op == OP_CE && st[win] == L_I) ? OP_RE : win_op;

  always_comb begin
    for (int i = 0; i < NM; i++) begin
      if (IW'(i) == win) tgt[i] = 1'b0;
      else if (eff_op == OP_RS) tgt[i] = st[i][1];
      else tgt[i] = (st[i] != L_I);
    end
  end

  assign needs_data = (cur_op == OP_RS) || (cur_op == OP_RE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= IDLE;
      cur_id  <= '0;
      cur_op  <= OP_RS;
      pend    <= '0;
      share_q <= 1'b0;
      wb_need <= 1'b0;
      wb_data <= '0;
      rd_data <= '0;
      for (int i = 0; i < NM; i++) st[i] <= L_I;
    end else begin
      case (phase)
        IDLE: if (|req_valid) begin
          cur_id  <= win;
          cur_op  <= eff_op;
          pend    <= tgt;
          share_q <= (eff_op == OP_RS);
          wb_need <= 1'b0;
          phase   <= SNP;
        end
        SNP: begin
          for (int i = 0; i < NM; i++) begin
            if (pend[i] && snp_ack[i]) begin
              pend[i] <= 1'b0;
              st[i]   <= share_q ? L_SC : L_I;
              if (st[i] == L_UD && cur_op != OP_ME) begin
                wb_need <= 1'b1;
                wb_data <= snp_data[i*DW +: DW];
              end
            end
          end
          if (pend == '0)
            phase <= wb_need ? WB : (needs_data ? RD : RSP);
        end
        WB: if (mem_wr_ack) phase <= needs_data ? RD : RSP;
        RD: if (mem_rd_valid) begin
          rd_data <= mem_rd_data;
          phase   <= RSP;
        end
        RSP: begin
          st[cur_id] <= (cur_op == OP_RS) ? L_SC : (cur_op == OP_ME) ? L_UD : L_UC;
          phase      <= IDLE;
        end
        default: phase <= IDLE;
      endcase
    end
  end

  assign busy         = (phase != IDLE);
  assign snp_valid    = (phase == SNP) ? pend : '0;
  assign snp_share    = share_q;
  assign mem_wr_en    = (phase == WB);
  assign mem_wr_data  = wb_data;
  assign mem_rd_en    = (phase == RD);
  assign rsp_valid    = (phase == RSP) ? (NM'(1) << cur_id) : '0;
  assign rsp_has_data = (phase == RSP) && needs_data;
  assign rsp_data     = rsp_has_data ? rd_data : '0;

  genvar g;
  generate
    for (g = 0; g < NM; g++) begin : g_ls
      assign line_state[2*g +: 2] = st[g];
    end
  endgenerate
endmodule

// File: rtl/line_owner_ctrl_chk.sv
module line_owner_ctrl_chk #(
  parameter int NM = 4,
  parameter int DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic [NM-1:0]   rsp_valid,
  input logic [NM-1:0]   snp_valid,
  input logic [NM-1:0]   snp_ack,
  input logic            mem_wr_en,
  input logic            mem_wr_ack,
  input logic            mem_rd_en,
  input logic [2*NM-1:0] line_state
);
  logic uniq_bad;

  always_comb begin
    uniq_bad = 1'b0;
    for (int i = 0; i < NM; i++)
      if (line_state[2*i+1])
        for (int j = 0; j < NM; j++)
          if (j != i && line_state[2*j +: 2] != 2'd0) uniq_bad = 1'b1;
  end

  // R2
  unique_alone_chk: assert property (@(posedge clk) disable iff (!rst_n) !uniq_bad);

  // R12
  rsp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rsp_valid));

  // R12
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid != '0) |=> (rsp_valid == '0));

  // R12
  rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid != '0) |-> (snp_valid == '0 && !mem_wr_en && !mem_rd_en && busy));

  // R5
  rd_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (!mem_wr_en && snp_valid == '0));

  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !mem_wr_ack) |=> mem_wr_en);

  // R3
  snp_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid != '0) |-> busy);

  genvar g;
  generate
    for (g = 0; g < NM; g++) begin : g_hold
      // R11
      snp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid[g] && !snp_ack[g]) |=> snp_valid[g]);
    end
  endgenerate
endmodule

bind line_owner_ctrl line_owner_ctrl_chk #(.NM(NM), .DW(DW)) chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rsp_valid(rsp_valid),
  .snp_valid(snp_valid), .snp_ack(snp_ack), .mem_wr_en(mem_wr_en),
  .mem_wr_ack(mem_wr_ack), .mem_rd_en(mem_rd_en), .line_state(line_state)
);

// File: tb/line_owner_ctrl_test.sv
module line_owner_ctrl_test;
  localparam int NM = 4;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NM-1:0] req_valid = '0;
  logic [2*NM-1:0] req_op = '0;
  logic busy, rsp_has_data, snp_share, mem_wr_en, mem_rd_en;
  logic [NM-1:0] rsp_valid, snp_valid;
  logic [NM-1:0] snp_ack = '0;
  logic [DW-1:0] rsp_data, mem_wr_data;
  logic [DW-1:0] mem_rd_data = '0;
  logic [NM*DW-1:0] snp_data;
  logic mem_wr_ack = 1'b0, mem_rd_valid = 1'b0;
  logic [2*NM-1:0] line_state;

  logic [DW-1:0] mem;
  logic [DW-1:0] cdata [NM];
  int wr_cnt, rd_cnt, cyc, wr_cyc, rd_cyc;
  int snp_cnt [NM];
  logic last_share;
  int n_chk = 0, n_bad = 0;
  logic got_has;
  logic [DW-1:0] got_data;

  always #4 clk = ~clk;

  line_owner_ctrl #(.NM(NM), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_has_data(rsp_has_data),
    .rsp_data(rsp_data), .snp_valid(snp_valid), .snp_share(snp_share),
    .snp_ack(snp_ack), .snp_data(snp_data), .mem_wr_en(mem_wr_en),
    .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack), .mem_rd_en(mem_rd_en),
    .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid), .line_state(line_state)
  );

  always_comb
    for (int i = 0; i < NM; i++) snp_data[i*DW +: DW] = cdata[i];

  always @(posedge clk) begin
    if (!rst_n) begin
      mem <= 32'hA5A5_0001;
      wr_cnt <= 0; rd_cnt <= 0; cyc <= 0; wr_cyc <= 0; rd_cyc <= 0;
      mem_wr_ack <= 1'b0; mem_rd_valid <= 1'b0; snp_ack <= '0;
      last_share <= 1'b0;
      for (int i = 0; i < NM; i++) snp_cnt[i] <= 0;
    end else begin
      cyc <= cyc + 1;
      mem_wr_ack <= mem_wr_en && !mem_wr_ack;
      if (mem_wr_en && mem_wr_ack) begin
        mem <= mem_wr_data; wr_cnt <= wr_cnt + 1; wr_cyc <= cyc;
      end
      mem_rd_valid <= mem_rd_en && !mem_rd_valid;
      mem_rd_data <= mem;
      if (mem_rd_en && mem_rd_valid) begin
        rd_cnt <= rd_cnt + 1; rd_cyc <= cyc;
      end
      snp_ack <= snp_valid & ~snp_ack;
      for (int i = 0; i < NM; i++)
        if (snp_valid[i] && snp_ack[i]) begin
          snp_cnt[i] <= snp_cnt[i] + 1;
          last_share <= snp_share;
        end
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_req(input int id, input logic [1:0] op);
    int t;
    @(negedge clk);
    req_op[2*id +: 2] = op;
    req_valid[id] = 1'b1;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!rsp_valid[id] && t < 200);
    check("R12 response seen", {63'd0, rsp_valid[id]}, 64'd1);
    got_has = rsp_has_data;
    got_data = rsp_data;
    req_valid[id] = 1'b0;
    @(negedge clk);
    check("R12 response single cycle", {60'd0, rsp_valid}, 64'd0);
  endtask

  task automatic t_reset;
    check("R1 states", line_state, 0);
    check("R1 busy", busy, 0);
    check("R1 idle outputs", {rsp_valid, snp_valid, mem_wr_en, mem_rd_en}, 0);
  endtask

  task automatic t_read_excl_alone;
    int w0 = wr_cnt, r0 = rd_cnt;
    do_req(1, 2'd1);
    check("R4 has data", got_has, 1);
    check("R4 data", got_data, 32'hA5A5_0001);
    check("R4 state UC", line_state, 8'h08);
    check("R6 no write", wr_cnt - w0, 0);
    check("R4 one read", rd_cnt - r0, 1);
  endtask

  task automatic t_make_excl;
    int w0 = wr_cnt, r0 = rd_cnt, s1 = snp_cnt[1];
    do_req(2, 2'd3);
    check("R9 no data", got_has, 0);
    check("R9 states", line_state, 8'h30);
    check("R9 snooped M1", snp_cnt[1] - s1, 1);
    check("R11 invalidate kind", last_share, 0);
    check("R9 no mem", (wr_cnt - w0) + (rd_cnt - r0), 0);
    cdata[2] = 32'h1234_5678;
  endtask

  task automatic t_read_excl_dirty;
    int w0 = wr_cnt;
    do_req(0, 2'd1);
    check("R5 one write", wr_cnt - w0, 1);
    check("R5 mem updated", mem, 32'h1234_5678);
    check("R5 newest data", got_data, 32'h1234_5678);
    check("R5 write before read", rd_cyc > wr_cyc, 1);
    check("R4 states", line_state, 8'h02);
  endtask

  task automatic t_make_discard;
    int w0;
    do_req(3, 2'd3);
    check("R9 states M3", line_state, 8'hC0);
    cdata[3] = 32'hDEAD_0003;
    w0 = wr_cnt;
    do_req(1, 2'd3);
    check("R9 dirty dropped", wr_cnt - w0, 0);
    check("R9 mem unchanged", mem, 32'h1234_5678);
    check("R2 states M1 only", line_state, 8'h0C);
    cdata[1] = 32'h0000_0055;
  endtask

  task automatic t_read_shared;
    int w0 = wr_cnt, s1, s2;
    do_req(2, 2'd0);
    check("R10 writeback", wr_cnt - w0, 1);
    check("R10 mem", mem, 32'h55);
    check("R11 share kind", last_share, 1);
    check("R10 data", got_data, 32'h55);
    check("R10 states", line_state, 8'h14);
    w0 = wr_cnt; s1 = snp_cnt[1]; s2 = snp_cnt[2];
    do_req(0, 2'd0);
    check("R10 no snoop of shared", (snp_cnt[1] - s1) + (snp_cnt[2] - s2), 0);
    check("R10 no write", wr_cnt - w0, 0);
    check("R10 data second", got_data, 32'h55);
    check("R10 three shared", line_state, 8'h15);
  endtask

  task automatic t_clean_excl;
    int w0 = wr_cnt, r0 = rd_cnt, s1 = snp_cnt[1], s2 = snp_cnt[2];
    do_req(0, 2'd2);
    check("R7 no data", got_has, 0);
    check("R7 others snooped", (snp_cnt[1] - s1) + (snp_cnt[2] - s2), 2);
    check("R7 states", line_state, 8'h02);
    check("R7 no mem", (wr_cnt - w0) + (rd_cnt - r0), 0);
  endtask

  task automatic t_clean_from_invalid;
    int w0 = wr_cnt, r0 = rd_cnt, s0 = snp_cnt[0];
    do_req(3, 2'd2);
    check("R8 has data", got_has, 1);
    check("R8 data", got_data, 32'h55);
    check("R8 read", rd_cnt - r0, 1);
    check("R6 clean holder no write", wr_cnt - w0, 0);
    check("R8 snooped M0", snp_cnt[0] - s0, 1);
    check("R8 states", line_state, 8'h80);
  endtask

  task automatic t_arbitrate;
    int t;
    @(negedge clk);
    req_op = 8'hFF;
    req_valid = 4'b0110;
    @(negedge clk);
    check("R3 busy after accept", busy, 1);
    t = 0;
    while (rsp_valid == '0 && t < 200) begin
      @(negedge clk);
      t++;
    end
    check("R3 lowest first", rsp_valid, 4'b0010);
    req_valid[1] = 1'b0;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!rsp_valid[2] && t < 200);
    check("R3 second served", rsp_valid, 4'b0100);
    req_valid[2] = 1'b0;
    @(negedge clk);
    check("R3 final states", line_state, 8'h30);
    check("R3 idle", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < NM; i++) cdata[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_excl_alone();
    t_make_excl();
    t_read_excl_dirty();
    t_make_discard();
    t_read_shared();
    t_clean_excl();
    t_clean_from_invalid();
    t_arbitrate();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual expired expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule